// File: doc/BRIEF.md
# Memory Map with Rotate Windows

This block sits between a small CPU core and its storage. Every cycle the core may present a 12-bit address with an access enable, a write enable, 6-bit write data and its current 12-bit program counter. The block decodes the address into one of five regions. The regions are RAM, a program-counter window, a gap, a rotate-left window and a rotate-right window. It returns 6-bit read data one cycle after a read access.

The low part of the address space is a 3902-word RAM that can be read and written. Directly above the RAM, two read-only addresses return the halves of the program counter. The top two 64-word windows of the space hold no storage. A read there returns the address's own low six bits rotated by one place, which gives a core with only bitwise logic a way to move bits between positions. Writes outside RAM change nothing. Any access to the unmapped gap raises an error pulse. A separate preload port fills RAM while the core is held in reset.

Top module: `mm_memory_map`

## Requirements
- R1: Addresses 0x000..0xF3D are RAM. A write access stores the data. A read access presents the stored word on the read data port in the cycle after the access.
- R2: A read of 0xF3E returns pc[5:0] and a read of 0xF3F returns pc[11:6]. The pc value used is the one present in the access cycle. The data appears one cycle later.
- R3: A read anywhere in 0xF80..0xFBF returns the address's low six bits a[5:0] rotated left by one, i.e. {a[4:0], a[5]}, one cycle later.
- R4: A read anywhere in 0xFC0..0xFFF returns a[5:0] rotated right by one, i.e. {a[0], a[5:1]}, one cycle later.
- R5: A write access at any address from 0xF3E upward changes no RAM word.
- R6: A read in the gap 0xF40..0xF7F returns zero one cycle later.
- R7: The decode error output is high in exactly the cycle after an access (read or write) to the gap 0xF40..0xF7F. It is low in every other cycle.
- R8: The read data output keeps its value through any cycle that follows an idle cycle or a write access.
- R9: While reset (active low) is applied, the read data is zero and the decode error is low.
- R10: A preload strobe writes its data to its RAM address only while reset is applied. With reset released, the preload port has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_en | input | 1 | Access request this cycle |
| acc_we | input | 1 | 1 = write access, 0 = read access |
| acc_addr | input | 12 | Access address |
| acc_wdata | input | 6 | Write data |
| pc | input | 12 | Current program counter of the core |
| pl_en | input | 1 | Preload strobe, honoured only in reset |
| pl_addr | input | 12 | Preload RAM address |
| pl_data | input | 6 | Preload data |
| rd_data | output | 6 | Read result, valid the cycle after a read |
| dec_err | output | 1 | One-cycle pulse after a gap access |

## Verification
Random RAM traffic runs against a bench-side memory model. This separates correct storage and one-cycle latency from stale or misaddressed words. Reads spread across both rotate windows and compare against rotations computed in the bench. This tells a left rotation from a right one and catches a swapped or mis-bounded window. Directed accesses at each region edge pin the decode thresholds: 0xF3D, 0xF3E, 0xF3F, 0xF40, 0xF7F, 0xF80, 0xFBF, 0xFC0 and 0xFFF. Writes outside RAM, idle cycles and late preload strobes are each followed by a read-back. This shows that those inputs left RAM and the read port untouched.

// File: rtl/mm_pkg.sv
package mm_pkg;
  typedef enum logic [2:0] {
    RG_RAM  = 3'd0,
    RG_PCLO = 3'd1,
    RG_PCHI = 3'd2,
    RG_GAP  = 3'd3,
    RG_ROTL = 3'd4,
    RG_ROTR = 3'd5
  } region_e;
endpackage

// File: rtl/mm_decode.sv
module mm_decode
  import mm_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int DATA_W    = 6,
  parameter int RAM_WORDS = 3902
) (
  input  logic [ADDR_W-1:0] addr,
  output region_e           region
);
  localparam int WIN = 2 ** DATA_W;
  localparam logic [ADDR_W-1:0] PCLO_A    = ADDR_W'(RAM_WORDS);
  localparam logic [ADDR_W-1:0] PCHI_A    = ADDR_W'(RAM_WORDS + 1);
  localparam logic [ADDR_W-1:0] ROTR_BASE = ADDR_W'((2 ** ADDR_W) - WIN);
  localparam logic [ADDR_W-1:0] ROTL_BASE = ADDR_W'((2 ** ADDR_W) - 2 * WIN);

  always_comb begin
    if (addr < PCLO_A)          region = RG_RAM;
    else if (addr == PCLO_A)    region = RG_PCLO;
    else if (addr == PCHI_A)    region = RG_PCHI;
    else if (addr >= ROTR_BASE) region = RG_ROTR;
    else if (addr >= ROTL_BASE) region = RG_ROTL;
    else                        region = RG_GAP;
  end
endmodule

// File: rtl/mm_ram.sv
module mm_ram #(
  parameter int DATA_W = 6,
  parameter int DEPTH  = 3902,
  parameter int AW     = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_stb,
  input  logic [AW-1:0]     rd_addr,
  input  logic              wr_stb,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              pl_we,
  input  logic [AW-1:0]     pl_addr,
  input  logic [DATA_W-1:0] pl_data,
  output logic [DATA_W-1:0] q
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (pl_we)       mem[pl_addr] <= pl_data;
    else if (wr_stb) mem[wr_addr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      q <= '0;
    else if (rd_stb) q <= mem[rd_addr];
  end

  // R5: the CPU write strobe only reaches addresses inside the array
  a_r5_write_in_ram: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> wr_addr <= LAST);
  // R10: preload writes only happen while reset is applied
  a_r10_preload_in_reset: assert property (@(posedge clk)
    pl_we |-> !rst_n);
endmodule

// File: rtl/mm_readpath.sv
module mm_readpath
  import mm_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_stb,
  input  region_e           region,
  input  logic [DATA_W-1:0] addr_lo,
  input  logic [ADDR_W-1:0] pc,
  input  logic [DATA_W-1:0] ram_q,
  output logic [DATA_W-1:0] rd_data
);
  function automatic logic [DATA_W-1:0] rot_left(input logic [DATA_W-1:0] v);
    return {v[DATA_W-2:0], v[DATA_W-1]};
  endfunction

  function automatic logic [DATA_W-1:0] rot_right(input logic [DATA_W-1:0] v);
    return {v[0], v[DATA_W-1:1]};
  endfunction

  logic [DATA_W-1:0] comp_d, comp_q;
  logic              from_ram_q;

  always_comb begin
    unique case (region)
      RG_PCLO: comp_d = pc[DATA_W-1:0];
      RG_PCHI: comp_d = pc[ADDR_W-1:ADDR_W-DATA_W];
      RG_ROTL: comp_d = rot_left(addr_lo);
      RG_ROTR: comp_d = rot_right(addr_lo);
      default: comp_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      comp_q     <= '0;
      from_ram_q <= 1'b0;
    end else if (rd_stb) begin
      comp_q     <= comp_d;
      from_ram_q <= (region == RG_RAM);
    end
  end

  assign rd_data = from_ram_q ? ram_q : comp_q;

  // R3: a rotate-left window read yields the rotated address bits next cycle
  a_r3_rotl: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && region == RG_ROTL) |=> rd_data == {$past(addr_lo[DATA_W-2:0]), $past(addr_lo[DATA_W-1])});
  // R4: a rotate-right window read yields the rotated address bits next cycle
  a_r4_rotr: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && region == RG_ROTR) |=> rd_data == {$past(addr_lo[0]), $past(addr_lo[DATA_W-1:1])});
  // R2: program counter halves come from the access cycle
  a_r2_pclo: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && region == RG_PCLO) |=> rd_data == $past(pc[DATA_W-1:0]));
  // R6: gap reads return zero
  a_r6_gap_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && region == RG_GAP) |=> rd_data == '0);
  // R8: no read strobe, no change on the read port
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stb |=> $stable(rd_data));
endmodule

// File: rtl/mm_memory_map.sv
module mm_memory_map
  import mm_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int DATA_W    = 6,
  parameter int RAM_WORDS = 3902
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_en,
  input  logic              acc_we,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [DATA_W-1:0] acc_wdata,
  input  logic [ADDR_W-1:0] pc,
  input  logic              pl_en,
  input  logic [ADDR_W-1:0] pl_addr,
  input  logic [DATA_W-1:0] pl_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              dec_err
);
  localparam int RAM_AW = $clog2(RAM_WORDS);
  localparam logic [ADDR_W-1:0] RAM_END = ADDR_W'(RAM_WORDS);

  region_e           acc_region;
  logic              rd_stb, wr_stb, gap_hit, pl_we;
  logic [DATA_W-1:0] ram_q;

  mm_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .RAM_WORDS(RAM_WORDS)) u_decode (
    .addr   (acc_addr),
    .region (acc_region)
  );

  assign rd_stb  = acc_en && !acc_we;
  assign wr_stb  = acc_en && acc_we && (acc_region == RG_RAM);
  assign gap_hit = acc_en && (acc_region == RG_GAP);
  assign pl_we   = !rst_n && pl_en && (pl_addr < RAM_END);

  mm_ram #(.DATA_W(DATA_W), .DEPTH(RAM_WORDS), .AW(RAM_AW)) u_ram (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_stb  (rd_stb && acc_region == RG_RAM),
    .rd_addr (acc_addr[RAM_AW-1:0]),
    .wr_stb  (wr_stb),
    .wr_addr (acc_addr[RAM_AW-1:0]),
    .wr_data (acc_wdata),
    .pl_we   (pl_we),
    .pl_addr (pl_addr[RAM_AW-1:0]),
    .pl_data (pl_data),
    .q       (ram_q)
  );

  mm_readpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_readpath (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_stb  (rd_stb),
    .region  (acc_region),
    .addr_lo (acc_addr[DATA_W-1:0]),
    .pc      (pc),
    .ram_q   (ram_q),
    .rd_data (rd_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) dec_err <= 1'b0;
    else        dec_err <= gap_hit;
  end

  // R7: the error pulse follows a gap access and nothing else
  a_r7_err_follows_gap: assert property (@(posedge clk) disable iff (!rst_n)
    dec_err |-> $past(acc_en) && $past(acc_addr) >= RAM_END + ADDR_W'(2)
                && $past(acc_addr) < ADDR_W'((2 ** ADDR_W) - 2 * (2 ** DATA_W)));
  // R5: a write outside RAM never becomes a RAM write strobe
  a_r5_no_write_above_ram: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && acc_we && acc_addr >= RAM_END) |-> !wr_stb);
  // R9: reset state of the outputs
  a_r9_reset_state: assert property (@(posedge clk)
    !rst_n |=> (dec_err == 1'b0));
endmodule

// File: tb/mm_memory_map_tb.sv
`timescale 1ns/1ps
module mm_memory_map_tb;
  localparam int AW = 12;
  localparam int DW = 6;
  localparam int NW = 3902;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          acc_en, acc_we;
  logic [AW-1:0] acc_addr, pc, pl_addr;
  logic [DW-1:0] acc_wdata, pl_data, rd_data;
  logic          pl_en, dec_err;

  int            n_chk = 0;
  int            n_bad = 0;
  logic [DW-1:0] model [NW];
  logic [DW-1:0] last_rd;

  always #5 clk = ~clk;

  mm_memory_map u_dut (
    .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_we(acc_we),
    .acc_addr(acc_addr), .acc_wdata(acc_wdata), .pc(pc),
    .pl_en(pl_en), .pl_addr(pl_addr), .pl_data(pl_data),
    .rd_data(rd_data), .dec_err(dec_err)
  );

  function automatic logic [DW-1:0] expect_read(input int a, input logic [AW-1:0] p);
    logic [DW-1:0] lo;
    lo = DW'(a % 64);
    if (a < NW)        return model[a];
    if (a == NW)       return p[5:0];
    if (a == NW + 1)   return p[11:6];
    if (a >= 'hFC0)    return DW'((lo >> 1) | ((lo & 1) << 5));
    if (a >= 'hF80)    return DW'(((lo << 1) & 6'h3F) | (lo >> 5));
    return '0;
  endfunction

  function automatic bit in_gap(input int a);
    return a >= 'hF40 && a < 'hF80;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // one access, driven at a negedge and checked at the following negedge
  task automatic access(input bit en, input bit we, input int a,
                        input logic [DW-1:0] d, input logic [AW-1:0] p, input string req);
    logic [DW-1:0] exp_rd;
    bit            exp_err;
    acc_en = en; acc_we = we; acc_addr = AW'(a); acc_wdata = d; pc = p;
    exp_rd  = (en && !we) ? expect_read(a, p) : last_rd;
    exp_err = en && in_gap(a);
    @(posedge clk);
    @(negedge clk);
    if (en && we && a < NW) model[a] = d;
    check(req, rd_data, exp_rd);
    check("R7", dec_err, exp_err);
    last_rd = exp_rd;
    acc_en = 1'b0;
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    rst_n = 1'b0; acc_en = 1'b0; acc_we = 1'b0; acc_addr = '0;
    acc_wdata = '0; pc = '0; pl_en = 1'b0; pl_addr = '0; pl_data = '0;
    last_rd = '0;
    // R10: preload every RAM word while in reset
    for (int i = 0; i < NW; i++) begin
      @(negedge clk);
      pl_en = 1'b1; pl_addr = AW'(i); pl_data = DW'($urandom);
      model[i] = pl_data;
    end
    @(negedge clk);
    pl_en = 1'b0;
    check("R9", rd_data, 0);
    check("R9", dec_err, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R10: preload after reset release has no effect
    pl_en = 1'b1; pl_addr = 12'd100; pl_data = ~model[100];
    @(negedge clk);
    pl_en = 1'b0;
    access(1, 0, 100, 0, 0, "R10");

    // R1: RAM edges
    access(1, 1, 0, 6'h15, 0, "R1");
    access(1, 0, 0, 0, 0, "R1");
    access(1, 1, 'hF3D, 6'h2A, 0, "R1");
    access(1, 0, 'hF3D, 0, 0, "R1");
    // R5: writes above RAM leave RAM untouched; R8: write holds read data
    access(1, 1, 'hF3E, 6'h3F, 0, "R8");
    access(1, 1, 'hFFF, 6'h01, 0, "R8");
    access(1, 0, 'hF3D, 0, 0, "R5");
    access(1, 0, 0, 0, 0, "R5");
    // R2: program counter window
    access(1, 0, 'hF3E, 0, 12'hA5C, "R2");
    access(1, 0, 'hF3F, 0, 12'hA5C, "R2");
    // R6/R7: gap edges, read and write
    access(1, 0, 'hF40, 0, 0, "R6");
    access(1, 1, 'hF7F, 6'h11, 0, "R7");
    access(1, 0, 'hF7F, 0, 0, "R6");
    // R3/R4: window edges
    access(1, 0, 'hF80, 0, 0, "R3");
    access(1, 0, 'hFA1, 0, 0, "R3");
    access(1, 0, 'hFBF, 0, 0, "R3");
    access(1, 0, 'hFC0, 0, 0, "R4");
    access(1, 0, 'hFC1, 0, 0, "R4");
    access(1, 0, 'hFFF, 0, 0, "R4");
    // R8: idle cycles hold
    access(0, 0, 'hF50, 0, 0, "R8");
    access(0, 1, 5, 6'h3, 0, "R8");
    access(1, 0, 5, 0, 0, "R1");

    // random traffic over all regions
    for (int k = 0; k < 3000; k++) begin
      int  sel, a;
      bit  en, we;
      sel = int'($urandom % 8);
      en  = ($urandom % 8) != 0;
      we  = ($urandom % 3) == 0;
      case (sel)
        0, 1, 2: a = int'($urandom % NW);
        3:       a = NW + int'($urandom % 2);
        4:       a = 'hF40 + int'($urandom % 64);
        5:       a = 'hF80 + int'($urandom % 64);
        6:       a = 'hFC0 + int'($urandom % 64);
        default: a = int'($urandom % 16) + NW - 8;
      endcase
      access(en, we, a, DW'($urandom), AW'($urandom), "R1");
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule